// File: doc/BRIEF.md
# Packet-Size Memory Request Coalescer

This block collects 8-byte read requests issued by several threads and folds them into fewer, larger packet requests for a packetized stacked-memory link. It sits where a data cache would otherwise be. It gives locality gains both to linear streams and to scattered, irregular streams, because requests from different threads that land near each other in memory leave as one packet.

Requests arrive on a valid/ready stream. Each request carries a thread ID, a tag and a byte address. They fill a window of slots in arrival order. The window is flushed when it is full, or when its oldest entry has waited for a programmable number of cycles. During a flush, a binary minimum-search tree repeatedly finds the lowest remaining address. All remaining requests in the same 256-byte region as that address leave as one packet. The packet has the smallest legal size that is aligned to that size and covers all of them.

Each packet carries its base address, a size code and a bitmap of the window slots it serves. A downstream response splitter uses that bitmap, together with a slot lookup port, to recover every thread's tag. This includes the tags of requests that share an address.

Top module: `req_coalescer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: While the block is gathering and no flush is starting, a request is taken when `in_valid` and `in_ready` are both high. It is stored in slot `n`, where `n` counts the requests already in the window, starting at 0. Address bits [2:0] are ignored. When all DEPTH slots are filled, `in_ready` is low from the next cycle on.
- R3: A flush starts when the window holds at least one request and the age counter has reached `cfg_timeout`. The age counter is 0 in the cycle after the first request enters an empty window and rises by one every later cycle. From the cycle after that, `out_valid` is high.
- R4: While `out_valid` is high, `in_ready` is low and no request is taken.
- R5: The packets of one flush are emitted in strictly ascending base-address order. Each one starts from the lowest address still pending.
- R6: `out_size` code n means a packet of 16<<n bytes, so codes 0 to 4 mean 16 to 256 bytes. The code is the smallest one for which a block of that size, aligned to that size, holds the lowest pending address and every other pending request in its 256-byte region. `out_base` is that block's start, with its low 4+n bits zero.
- R7: Bit i of `out_members` is set exactly when slot i is one of the requests the packet covers. Requests with equal addresses from different threads appear together in a single packet.
- R8: While `out_valid` is high and `out_ready` is low, `out_base`, `out_size` and `out_members` hold their values.
- R9: `peek_tid` and `peek_tag` give the thread ID and tag stored in slot `peek_slot` in the same cycle. Slot contents remain readable after the flush until the slot is written again.
- R10: When the last pending request has been sent, the block goes back to gathering with an empty window. It raises `in_ready` in the following cycle, and the next request goes into slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TOW (12) | Flush age limit in cycles |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_tid | input | TIDW (4) | Requesting thread |
| in_tag | input | TAGW (8) | Thread's request tag |
| in_addr | input | AW (32) | Byte address of the 8-byte read |
| out_valid | output | 1 | Packet present |
| out_ready | input | 1 | Downstream takes the packet |
| out_base | output | AW (32) | Packet start byte address |
| out_size | output | 3 | Size code, 16<<code bytes |
| out_members | output | DEPTH (16) | Window slots served by this packet |
| peek_slot | input | log2(DEPTH) (4) | Slot to look up |
| peek_tid | output | TIDW (4) | Thread ID stored in that slot |
| peek_tag | output | TAGW (8) | Tag stored in that slot |

## Verification
The embedded properties rely on `cfg_timeout` staying constant for as long as the window holds requests. The stimulus changes it only after a long idle drain, when the window is empty. They also rely on a request holding its fields until it is taken, and the stimulus keeps each offered request unchanged until the cycle after the edge that accepts it. `out_ready` is toggled at random, so packets stall, which exercises the hold property. The address patterns are chosen to make flushes from a full window and from a timeout, duplicate addresses across threads, and every size code.

// File: rtl/rc_pkg.sv
package rc_pkg;
   localparam int RC_NSIZES  = 5;   // 16, 32, 64, 128, 256 bytes
   localparam int RC_WORDLOG = 3;   // requests are 8-byte words
   localparam int RC_REGLOG  = 8;   // packets never cross a 256-byte region

   typedef enum logic [2:0] {
      RC_SZ16  = 3'd0,
      RC_SZ32  = 3'd1,
      RC_SZ64  = 3'd2,
      RC_SZ128 = 3'd3,
      RC_SZ256 = 3'd4
   } rc_size_e;

   typedef enum logic {
      RC_GATHER = 1'b0,
      RC_DRAIN  = 1'b1
   } rc_phase_e;
endpackage

// File: rtl/rc_min_tree.sv
module rc_min_tree #(
   parameter int N = 16,
   parameter int W = 29
) (
   input  logic [N-1:0]   vld,
   input  logic [N*W-1:0] keys,
   output logic           any,
   output logic [W-1:0]   min_key
);
   localparam int NODES = 2*N - 1;

   if (N < 2) begin : g_bad_n
      $error("rc_min_tree: N must be at least 2");
   end

   // heap layout: node i has children 2i+1 and 2i+2, leaves from N-1
   logic [NODES-1:0]        nv;
   logic [NODES-1:0][W-1:0] nk;

   for (genvar j = 0; j < N; j++) begin : g_leaf
      assign nv[N-1+j] = vld[j];
      assign nk[N-1+j] = keys[j*W +: W];
   end

   for (genvar i = 0; i < N-1; i++) begin : g_node
      logic take_r;
      assign take_r = nv[2*i+2] && (!nv[2*i+1] || (nk[2*i+2] < nk[2*i+1]));
      assign nv[i]  = nv[2*i+1] || nv[2*i+2];
      assign nk[i]  = take_r ? nk[2*i+2] : nk[2*i+1];
   end

   assign any     = nv[0];
   assign min_key = nk[0];
endmodule

// File: rtl/rc_packet_former.sv
module rc_packet_former
   import rc_pkg::*;
#(
   parameter int N  = 16,
   parameter int WA = 29
) (
   input  logic [N-1:0]    live,
   input  logic [N*WA-1:0] words,
   input  logic [WA-1:0]   min_word,
   output rc_size_e        size,
   output logic [WA-1:0]   base_word,
   output logic [N-1:0]    members
);
   localparam int RSH = RC_REGLOG - RC_WORDLOG;   // word bits inside a region

   if (WA <= RSH) begin : g_bad_wa
      $error("rc_packet_former: word address narrower than a region");
   end

   logic [RC_NSIZES-1:0][N-1:0] fit;
   logic [RC_NSIZES-1:0]        ok;

   for (genvar j = 0; j < N; j++) begin : g_slot
      logic [WA-1:0] w;
      assign w          = words[j*WA +: WA];
      assign members[j] = live[j] && (w[WA-1:RSH] == min_word[WA-1:RSH]);
      for (genvar k = 0; k < RC_NSIZES; k++) begin : g_sz
         // a block of 16<<k bytes spans 2<<k words
         assign fit[k][j] = !members[j] || ((w >> (k+1)) == (min_word >> (k+1)));
      end
   end

   for (genvar k = 0; k < RC_NSIZES; k++) begin : g_ok
      assign ok[k] = &fit[k];
   end

   always_comb begin
      size = RC_SZ256;
      for (int k = RC_NSIZES-1; k >= 0; k--) begin
         if (ok[k]) size = rc_size_e'(3'(k));
      end
   end

   assign base_word = min_word & ~((WA'(2) << size) - WA'(1));
endmodule

// File: rtl/req_coalescer.sv
module req_coalescer
   import rc_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DEPTH    = 16,
   parameter int TIDW     = 4,
   parameter int TAGW     = 8,
   parameter int TOW      = 12,
   parameter bit PEEK_REG = 1'b0,
   localparam int SW      = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TOW-1:0]  cfg_timeout,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [TIDW-1:0] in_tid,
   input  logic [TAGW-1:0] in_tag,
   input  logic [AW-1:0]   in_addr,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [AW-1:0]   out_base,
   output logic [2:0]      out_size,
   output logic [DEPTH-1:0] out_members,
   input  logic [SW-1:0]   peek_slot,
   output logic [TIDW-1:0] peek_tid,
   output logic [TAGW-1:0] peek_tag
);
   localparam int WA = AW - RC_WORDLOG;
   localparam int FW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << SW) != DEPTH) begin : g_bad_depth
      $error("req_coalescer: DEPTH must be a power of two, at least 2");
   end
   if (AW <= RC_REGLOG) begin : g_bad_aw
      $error("req_coalescer: AW too narrow");
   end

   rc_phase_e                    phase;
   logic [FW-1:0]                fill;
   logic [TOW-1:0]               age;
   logic [DEPTH-1:0]             live;
   logic [DEPTH-1:0][WA-1:0]     st_word;
   logic [DEPTH-1:0][TIDW-1:0]   st_tid;
   logic [DEPTH-1:0][TAGW-1:0]   st_tag;

   logic            flush_go, accept, pop, last;
   logic            tree_any;
   logic [WA-1:0]   min_word, base_word;
   rc_size_e        pkt_size;
   logic [DEPTH-1:0] pkt_members;
   logic            unused_lowbits;

   assign unused_lowbits = ^in_addr[RC_WORDLOG-1:0];

   assign flush_go  = (phase == RC_GATHER) &&
                      ((fill == FW'(DEPTH)) || ((fill != '0) && (age >= cfg_timeout)));
   assign in_ready  = (phase == RC_GATHER) && !flush_go;
   assign accept    = in_valid && in_ready;
   assign out_valid = (phase == RC_DRAIN);
   assign pop       = out_valid && out_ready;
   assign last      = pop && ((live & ~pkt_members) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= RC_GATHER;
         fill  <= '0;
         age   <= '0;
      end else if (phase == RC_GATHER) begin
         if (flush_go) begin
            phase <= RC_DRAIN;
         end else begin
            if (accept) fill <= fill + FW'(1);
            if (fill == '0)      age <= '0;
            else if (age != '1)  age <= age + TOW'(1);
         end
      end else if (last) begin
         phase <= RC_GATHER;
         fill  <= '0;
         age   <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      live <= '0;
      else if (pop)    live <= live & ~pkt_members;
      else if (accept) live[fill[SW-1:0]] <= 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_store
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_word[i] <= '0;
            st_tid[i]  <= '0;
            st_tag[i]  <= '0;
         end else if (accept && (fill == FW'(i))) begin
            st_word[i] <= in_addr[AW-1:RC_WORDLOG];
            st_tid[i]  <= in_tid;
            st_tag[i]  <= in_tag;
         end
      end
   end

   rc_min_tree #(.N(DEPTH), .W(WA)) u_min (
      .vld     (live),
      .keys    (st_word),
      .any     (tree_any),
      .min_key (min_word)
   );

   rc_packet_former #(.N(DEPTH), .WA(WA)) u_form (
      .live      (live),
      .words     (st_word),
      .min_word  (min_word),
      .size      (pkt_size),
      .base_word (base_word),
      .members   (pkt_members)
   );

   assign out_base    = {base_word, {RC_WORDLOG{1'b0}}};
   assign out_size    = pkt_size;
   assign out_members = pkt_members;

   if (PEEK_REG) begin : g_peek_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            peek_tid <= '0;
            peek_tag <= '0;
         end else begin
            peek_tid <= st_tid[peek_slot];
            peek_tag <= st_tag[peek_slot];
         end
      end
   end else begin : g_peek_comb
      assign peek_tid = st_tid[peek_slot];
      assign peek_tag = st_tag[peek_slot];
   end

   AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FW'(DEPTH)) |-> !in_ready);                                  // R2
   AST_TIMEOUT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == RC_GATHER) && (fill != '0) && (age >= cfg_timeout)) |=> out_valid); // R3
   AST_READY_LOW_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);                                             // R4
   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (!out_valid || (out_base > $past(out_base))));                // R5
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_base & ((AW'(16) << out_size) - AW'(1))) == '0)); // R6
   AST_MEMBERS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (tree_any && (out_members != '0) && ((out_members & ~live) == '0))); // R7
   AST_HOLD_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         ($stable(out_base) && $stable(out_size) && $stable(out_members))); // R8
endmodule

// File: tb/req_coalescer_bench.sv
module req_coalescer_bench;
   localparam int CLK_P = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_timeout = 12'd8;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_tid = '0;
   logic [7:0]  in_tag = '0;
   logic [31:0] in_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_base;
   logic [2:0]  out_size;
   logic [15:0] out_members;
   logic [3:0]  peek_slot = '0;
   logic [3:0]  peek_tid;
   logic [7:0]  peek_tag;

   always #(CLK_P/2) clk = ~clk;

   req_coalescer u_req_coalescer (
      .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
      .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid),
      .in_tag(in_tag), .in_addr(in_addr), .out_valid(out_valid),
      .out_ready(out_ready), .out_base(out_base), .out_size(out_size),
      .out_members(out_members), .peek_slot(peek_slot),
      .peek_tid(peek_tid), .peek_tag(peek_tag)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   int mode = 0;
   int lin_addr = 0;
   int ready_pct = 100;
   bit stop_in = 1'b0;
   bit done = 1'b0;

   // behavioural reference model
   bit          m_gather;
   int          m_fill, m_age;
   bit          m_live [DEPTH];
   logic [31:0] m_addr [DEPTH];
   logic [3:0]  m_tid  [DEPTH];
   logic [7:0]  m_tag  [DEPTH];
   bit          m_took;
   bit          m_stalled;

   function automatic bit m_go();
      return m_gather && (m_fill == DEPTH || (m_fill != 0 && m_age >= int'(cfg_timeout)));
   endfunction

   task automatic m_packet(output logic [31:0] base, output int sz, output logic [15:0] mem);
      logic [31:0] mn;
      bit found;
      found = 0; mn = '0; mem = '0;
      for (int j = 0; j < DEPTH; j++)
         if (m_live[j] && (!found || m_addr[j] < mn)) begin mn = m_addr[j]; found = 1; end
      for (int j = 0; j < DEPTH; j++)
         if (m_live[j] && (m_addr[j] >> 8) == (mn >> 8)) mem[j] = 1'b1;
      sz = 4;
      for (int k = 4; k >= 0; k--) begin
         bit fits;
         fits = 1;
         for (int j = 0; j < DEPTH; j++)
            if (mem[j] && (m_addr[j] >> (k+4)) != (mn >> (k+4))) fits = 0;
         if (fits) sz = k;
      end
      base = mn & ~((32'd16 << sz) - 32'd1);
   endtask

   task automatic m_reset();
      m_gather = 1; m_fill = 0; m_age = 0; m_took = 0; m_stalled = 0;
      for (int j = 0; j < DEPTH; j++) begin
         m_live[j] = 0; m_addr[j] = '0; m_tid[j] = '0; m_tag[j] = '0;
      end
   endtask

   initial m_reset();

   always @(posedge clk) begin
      m_took = 0;
      if (!rst_n) begin
         m_reset();
      end else if (m_gather) begin
         m_stalled = 0;
         if (m_go()) begin
            m_gather = 0;
         end else begin
            if (in_valid) begin
               m_addr[m_fill] = {in_addr[31:3], 3'b000};
               m_tid[m_fill]  = in_tid;
               m_tag[m_fill]  = in_tag;
               m_live[m_fill] = 1;
               m_took = 1;
            end
            if (m_fill == 0) m_age = 0; else m_age++;
            if (in_valid) m_fill++;
         end
      end else begin
         m_stalled = !out_ready;
         if (out_ready) begin
            logic [31:0] b; int s; logic [15:0] mm; bit any;
            m_packet(b, s, mm);
            any = 0;
            for (int j = 0; j < DEPTH; j++) begin
               if (mm[j]) m_live[j] = 0;
               if (m_live[j]) any = 1;
            end
            if (!any) begin m_gather = 1; m_fill = 0; m_age = 0; end
         end
      end
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [31:0] b; int s; logic [15:0] mm;
      string rq;
      rq = !m_gather ? "R4" : (m_fill == 0 ? "R10" : "R2");
      check(rq, "in_ready", 32'(in_ready), 32'(m_gather && !m_go()));
      check("R3", "out_valid", 32'(out_valid), 32'(!m_gather));
      if (!m_gather) begin
         m_packet(b, s, mm);
         check("R5", "out_base", out_base, b);
         check("R6", "out_size", 32'(out_size), 32'(s));
         check(m_stalled ? "R8" : "R7", "out_members", 32'(out_members), 32'(mm));
      end
      check("R9", "peek_tid", 32'(peek_tid), 32'(m_tid[peek_slot]));
      check("R9", "peek_tag", 32'(peek_tag), 32'(m_tag[peek_slot]));
   endtask

   task automatic drive_next();
      if (!in_valid || m_took) begin
         in_valid = !stop_in && ($urandom_range(0, 99) < 80);
         in_tid   = 4'($urandom);
         in_tag   = 8'($urandom);
         case (mode)
            0: in_addr = 32'h1000 + 32'($urandom_range(0, 127) * 8) + 32'($urandom_range(0, 7));
            1: begin in_addr = 32'h8000 + 32'(lin_addr * 8); lin_addr++; end
            2: in_addr = {$urandom, 3'b000} & 32'hFFFF_FFF8;
            default: in_addr = 32'h2000 + 32'($urandom_range(0, 7) * 8);
         endcase
      end
      out_ready = ($urandom_range(0, 99) < ready_pct);
      peek_slot = 4'($urandom);
   endtask

   task automatic run_phase(int md, int tmo, int rp, int n);
      mode = md; ready_pct = rp; stop_in = 0;
      // change the timeout only with an empty window
      stop_in = 1;
      repeat (4200) begin
         @(negedge clk);
         compare_all();
         drive_next();
         if (m_gather && m_fill == 0 && !in_valid) break;
      end
      cfg_timeout = 12'(tmo);
      stop_in = 0;
      repeat (n) begin
         @(negedge clk);
         compare_all();
         drive_next();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "in_ready in reset", 32'(in_ready), 32'd1);
      check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "in_ready after reset", 32'(in_ready), 32'd1);
      check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
      run_phase(0, 40, 100, 3000);   // full-window flushes, dense region
      run_phase(0, 40, 60, 3000);    // with stalls on the packet side
      run_phase(3, 3, 70, 2000);     // duplicates across threads, timeout flushes
      run_phase(1, 100, 80, 2000);   // linear stream
      run_phase(2, 6, 70, 2000);     // sparse scattered addresses
      run_phase(0, 0, 50, 2000);     // zero timeout
      run_phase(0, 5, 100, 20);
      stop_in = 1;
      repeat (200) begin
         @(negedge clk);
         compare_all();
         drive_next();
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=below 150000 cycles", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule